// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is a single channel of a multi-channel timer. It holds a down-counter, a reload value and a control/status word. Each cycle in which the shared prescaler tick is high and the channel is running, the counter drops by one. The channel expires when the counter would pass below zero, not when it reaches zero. A start value of N therefore gives a period of N+1 ticks.

On expiry the channel can raise a sticky pending flag and emit a one-cycle interrupt pulse. It can then either reload and keep running, or stop. Register writes arrive on a simple strobe/select/data port. Each write has its own side effect: a counter write restarts counting, a control write can force a reload, and a control write can clear the pending flag by writing one to it. Reads are a combinational select of the three registers. The prescaler and the address decode sit outside the block.

Top module: `udt_chan`

## Requirements
- R1: After reset the counter, reload and control words all read 0 and `irq_o` is low.
- R2: While running, each cycle with `tick_i` high lowers the counter by one. Without a tick, or while stopped, the counter holds.
- R3: A channel started at value N expires on the (N+1)-th tick after the start. The tick that finds the counter at 0 is the expiring tick.
- R4: On expiry with interrupt enable (control bit 3) set, pending (control bit 4) becomes 1 and `irq_o` is high for exactly the one cycle after the expiring tick. With bit 3 clear, neither pending nor `irq_o` changes.
- R5: On expiry with auto-restart (control bit 1) set, the counter takes the reload value and counting goes on; a reload value of 0 expires on every tick. With bit 1 clear, the channel stops and the counter holds 0.
- R6: A control write with bit 4 = 1 clears pending. A control write with bit 4 = 0 leaves pending as it was.
- R7: A control write with load (bit 2) = 1 copies the reload value into the counter. Bit 2 is never stored and always reads 0.
- R8: A counter write (select 0) sets the counter to the written value. The channel starts counting if enable is already set; otherwise it stays stopped.
- R9: A control write (select 2) stores enable in bit 0. Enable = 1 starts counting from the current counter value, and enable = 0 stops the channel.
- R10: Chain (bit 5) is stored and read back but has no effect. Debug-halt (bit 6) reads 0 and has no effect. Select 1 is the reload register, and select 3 reads 0 and ignores writes.
- R11: A write in the same cycle as a tick takes priority, and that tick has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Shared prescaler tick, one cycle per count step |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 counter, 1 reload, 2 control, 3 none |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as `wr_sel_i` |
| rd_data_o | output | DATA_W | Selected register value |
| irq_o | output | 1 | One-cycle interrupt pulse per expiry |

## Verification
On every cycle, the embedded properties check four things:
- a step of exactly one per running tick, and a still counter when neither a tick nor a write is present;
- that a write wins over a coincident tick;
- that the running state never outlives enable, and that a one-shot expiry stops the channel;
- that every interrupt pulse is matched by pending and by interrupt enable.

Only the bench scenarios can show the things that need a longer history:
- the N+1 tick period and back-to-back expiries with a zero reload;
- the sticky pending flag and its write-one clear;
- that the load bit reads 0, and that chain, debug-halt and the spare select have no effect.

// File: rtl/udt_pkg.sv
package udt_pkg;
   localparam int CTL_EN  = 0;
   localparam int CTL_AR  = 1;
   localparam int CTL_LD  = 2;
   localparam int CTL_IE  = 3;
   localparam int CTL_IP  = 4;
   localparam int CTL_CH  = 5;
   localparam int CTL_DH  = 6;
   localparam int CTL_NUM = 7;

   typedef enum logic [1:0] {
      SEL_CNT  = 2'd0,
      SEL_RLD  = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } udt_sel_e;
endpackage

// File: rtl/udt_ctrl_reg.sv
module udt_ctrl_reg
   import udt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              expire_i,
   output logic              en_o,
   output logic              ar_o,
   output logic              ie_o,
   output logic              ip_o,
   output logic              ch_o,
   output logic              irq_o
);
   logic en_q, ar_q, ie_q, ip_q, ch_q, irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ar_q  <= 1'b0;
         ie_q  <= 1'b0;
         ip_q  <= 1'b0;
         ch_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= expire_i & ie_q;
         if (wr_ctl_i) begin
            en_q <= wr_data_i[CTL_EN];
            ar_q <= wr_data_i[CTL_AR];
            ie_q <= wr_data_i[CTL_IE];
            ch_q <= wr_data_i[CTL_CH];
            if (wr_data_i[CTL_IP]) begin
               ip_q <= 1'b0;
            end
         end else if (expire_i && ie_q) begin
            ip_q <= 1'b1;
         end
      end
   end

   assign en_o  = en_q;
   assign ar_o  = ar_q;
   assign ie_o  = ie_q;
   assign ip_o  = ip_q;
   assign ch_o  = ch_q;
   assign irq_o = irq_q;

   AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ip_q); // R4
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ie_q); // R4
endmodule

// File: rtl/udt_count_core.sv
module udt_count_core
   import udt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              en_i,
   input  logic              ar_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] rld_o,
   output logic              run_o,
   output logic              expire_o
);
   localparam logic [DATA_W-1:0] ZERO = '0;
   localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] cnt_q, rld_q;
   logic              run_q;
   logic              wr_cnt, wr_rld, wr_ctl, step, at_zero;

   assign wr_cnt  = wr_en_i && (udt_sel_e'(wr_sel_i) == SEL_CNT);
   assign wr_rld  = wr_en_i && (udt_sel_e'(wr_sel_i) == SEL_RLD);
   assign wr_ctl  = wr_en_i && (udt_sel_e'(wr_sel_i) == SEL_CTL);
   assign step    = tick_i && run_q && !wr_en_i;
   assign at_zero = (cnt_q == ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         rld_q <= ZERO;
         run_q <= 1'b0;
      end else begin
         if (wr_rld) begin
            rld_q <= wr_data_i;
         end
         if (wr_cnt) begin
            cnt_q <= wr_data_i;
            run_q <= en_i;
         end else if (wr_ctl) begin
            run_q <= wr_data_i[CTL_EN];
            if (wr_data_i[CTL_LD]) begin
               cnt_q <= rld_q;
            end
         end else if (step) begin
            if (at_zero) begin
               if (ar_i) begin
                  cnt_q <= rld_q;
               end else begin
                  run_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign rld_o    = rld_q;
   assign run_o    = run_q;
   assign expire_o = step && at_zero;

   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && !wr_en_i && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_en_i) |=> $stable(cnt_q)); // R2
   AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> en_i); // R9
   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !ar_i) |=> (!run_q && at_zero)); // R5
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wr_data_i))); // R11
endmodule

// File: rtl/udt_rd_mux.sv
module udt_rd_mux
   import udt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rd_sel_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic [DATA_W-1:0] rld_i,
   input  logic [DATA_W-1:0] ctl_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      unique case (udt_sel_e'(rd_sel_i))
         SEL_CNT: sel_data = cnt_i;
         SEL_RLD: sel_data = rld_i;
         SEL_CTL: sel_data = ctl_i;
         default: sel_data = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= sel_data;
         end
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = sel_data;
   end
endmodule

// File: rtl/udt_chan.sv
module udt_chan
   import udt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   localparam int PAD_W = DATA_W - CTL_NUM;

   if (DATA_W < CTL_NUM) begin : g_bad_width
      $error("udt_chan: DATA_W must hold all control fields");
   end

   logic              en, ar, ie, ip, ch, run, expire, wr_ctl;
   logic [DATA_W-1:0] cnt, rld, ctl_word;

   assign wr_ctl = wr_en_i && (udt_sel_e'(wr_sel_i) == SEL_CTL);

   udt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl_i  (wr_ctl),
      .wr_data_i (wr_data_i),
      .expire_i  (expire),
      .en_o      (en),
      .ar_o      (ar),
      .ie_o      (ie),
      .ip_o      (ip),
      .ch_o      (ch),
      .irq_o     (irq_o)
   );

   udt_count_core #(.DATA_W(DATA_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .en_i      (en),
      .ar_i      (ar),
      .cnt_o     (cnt),
      .rld_o     (rld),
      .run_o     (run),
      .expire_o  (expire)
   );

   if (PAD_W > 0) begin : g_ctl_pad
      assign ctl_word = {{PAD_W{1'b0}}, 1'b0, ch, ip, ie, 1'b0, ar, en};
   end else begin : g_ctl_exact
      assign ctl_word = {1'b0, ch, ip, ie, 1'b0, ar, en};
   end

   udt_rd_mux #(.DATA_W(DATA_W), .RD_REG(RD_REG)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_sel_i  (rd_sel_i),
      .cnt_i     (cnt),
      .rld_i     (rld),
      .ctl_i     (ctl_word),
      .rd_data_o (rd_data_o)
   );

   AST_EXPIRE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (run && en && tick_i)); // R3
endmodule

// File: tb/udt_chan_tb.sv
module udt_chan_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   localparam logic [1:0] OP_W = 2'd0;  // write sel <- val
   localparam logic [1:0] OP_T = 2'd1;  // val ticks
   localparam logic [1:0] OP_C = 2'd2;  // read sel, expect val
   localparam logic [1:0] OP_I = 2'd3;  // irq pulses so far == val

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  sel;
      logic [31:0] val;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 52;
   localparam vec_t VECS [0:NV-1] = '{
      '{OP_W, 2'd1, 32'd5,    4'd7},
      '{OP_W, 2'd2, 32'h0D,   4'd7},
      '{OP_C, 2'd2, 32'h09,   4'd7},   // R7 load bit reads 0
      '{OP_C, 2'd0, 32'd5,    4'd7},   // R7 reload copied
      '{OP_T, 2'd0, 32'd5,    4'd2},
      '{OP_C, 2'd0, 32'd0,    4'd2},   // R2
      '{OP_I, 2'd0, 32'd0,    4'd3},   // R3 no expiry at zero
      '{OP_T, 2'd0, 32'd1,    4'd3},
      '{OP_I, 2'd0, 32'd1,    4'd3},   // R3 expiry on N+1
      '{OP_C, 2'd2, 32'h19,   4'd4},   // R4 pending set
      '{OP_T, 2'd0, 32'd3,    4'd5},
      '{OP_C, 2'd0, 32'd0,    4'd5},   // R5 one-shot stopped
      '{OP_I, 2'd0, 32'd1,    4'd5},
      '{OP_W, 2'd2, 32'h1B,   4'd6},
      '{OP_C, 2'd2, 32'h0B,   4'd6},   // R6 write one clears
      '{OP_T, 2'd0, 32'd1,    4'd5},
      '{OP_C, 2'd0, 32'd5,    4'd5},   // R5 auto reload
      '{OP_I, 2'd0, 32'd2,    4'd4},
      '{OP_T, 2'd0, 32'd6,    4'd3},
      '{OP_C, 2'd0, 32'd5,    4'd3},   // R3 period N+1
      '{OP_I, 2'd0, 32'd3,    4'd3},
      '{OP_W, 2'd2, 32'h0B,   4'd6},
      '{OP_C, 2'd2, 32'h1B,   4'd6},   // R6 write zero keeps
      '{OP_T, 2'd0, 32'd2,    4'd2},
      '{OP_C, 2'd0, 32'd3,    4'd2},   // R2
      '{OP_W, 2'd2, 32'h03,   4'd4},
      '{OP_C, 2'd2, 32'h13,   4'd4},
      '{OP_T, 2'd0, 32'd4,    4'd4},
      '{OP_C, 2'd0, 32'd5,    4'd5},   // R5
      '{OP_I, 2'd0, 32'd3,    4'd4},   // R4 no irq without enable
      '{OP_W, 2'd0, 32'd2,    4'd8},
      '{OP_C, 2'd0, 32'd2,    4'd8},   // R8
      '{OP_T, 2'd0, 32'd1,    4'd8},
      '{OP_C, 2'd0, 32'd1,    4'd8},   // R8 counts when enabled
      '{OP_W, 2'd2, 32'h10,   4'd9},
      '{OP_C, 2'd2, 32'h00,   4'd9},   // R9
      '{OP_T, 2'd0, 32'd3,    4'd9},
      '{OP_C, 2'd0, 32'd1,    4'd9},   // R9 stopped
      '{OP_W, 2'd0, 32'd7,    4'd8},
      '{OP_T, 2'd0, 32'd2,    4'd8},
      '{OP_C, 2'd0, 32'd7,    4'd8},   // R8 stays stopped
      '{OP_W, 2'd2, 32'h01,   4'd9},
      '{OP_T, 2'd0, 32'd2,    4'd9},
      '{OP_C, 2'd0, 32'd5,    4'd9},   // R9 starts from current
      '{OP_W, 2'd2, 32'h61,   4'd10},
      '{OP_C, 2'd2, 32'h21,   4'd10},  // R10 chain kept, halt 0
      '{OP_T, 2'd0, 32'd1,    4'd10},
      '{OP_C, 2'd0, 32'd4,    4'd10},  // R10 no effect
      '{OP_W, 2'd3, 32'hFFFFFFFF, 4'd10},
      '{OP_C, 2'd3, 32'd0,    4'd10},  // R10 spare select
      '{OP_C, 2'd1, 32'd5,    4'd10},
      '{OP_C, 2'd0, 32'd4,    4'd10}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_sel = 2'd0;
   logic [DW-1:0] rd_data;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   int irq_seen = 0;

   udt_chan #(.DATA_W(DW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (irq) irq_seen++;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input int req);
      #1;
      rd_sel = sel;
      #1;
      chk(rd_data, exp, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(2'd0, 32'd0, 1);
      rd_chk(2'd1, 32'd0, 1);
      rd_chk(2'd2, 32'd0, 1);
      chk({31'd0, irq}, 32'd0, 1);

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            OP_W: do_write(VECS[i].sel, VECS[i].val);
            OP_T: do_ticks(int'(VECS[i].val));
            OP_C: rd_chk(VECS[i].sel, VECS[i].val, int'(VECS[i].req));
            default: begin #1; chk(irq_seen, VECS[i].val, int'(VECS[i].req)); end
         endcase
      end

      // R11 write and tick in the same cycle: write wins
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd9;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd_chk(2'd0, 32'd9, 11);
      do_ticks(1);
      rd_chk(2'd0, 32'd8, 2);

      // R5 zero reload with auto-restart expires on every tick
      do_write(2'd1, 32'd0);
      do_write(2'd2, 32'h0F);
      rd_chk(2'd0, 32'd0, 7);
      do_ticks(3);
      #1;
      chk(irq_seen, 32'd6, 5);
      rd_chk(2'd0, 32'd0, 5);
      rd_chk(2'd2, 32'h1B, 4);

      // R1 reset while running
      do_write(2'd1, 32'd12);
      do_write(2'd2, 32'h0F);
      @(negedge clk);
      tick = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      tick = 1'b0;
      rst_n = 1'b1;
      rd_chk(2'd0, 32'd0, 1);
      rd_chk(2'd1, 32'd0, 1);
      rd_chk(2'd2, 32'd0, 1);
      chk({31'd0, irq}, 32'd0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule